// File: doc/BRIEF.md
# FIFO Threshold Offset Register Port

This block holds the two threshold offsets used by a FIFO's almost-empty and almost-full flag comparators, and gives software-free access to them through the FIFO's own data ports. The second write-enable pin has two possible meanings. The level on that pin while reset is asserted selects which meaning it has until the next reset.

If the pin is high during reset, it stays an ordinary second write enable and the offsets keep their reset value. If the pin is low during reset, it becomes a load strobe. In that mode, each strobed write cycle stores the write data word into one offset half. Each strobed read cycle returns one offset half on a registered read-data output.

Write accesses and read accesses each step through the four halves in a fixed circular order, and each has its own pointer. The block also produces qualified FIFO write and read strobes, which are suppressed while an offset access is in progress. The current offsets are registered outputs.

Top module: `fifo_ofs_port`

## Requirements
- R1: When the second enable pin (`wen_b_ld`) is high during reset, `load_mode` is 0 afterwards. No combination of enables alters either offset, `rdata_vld` stays 0, `fifo_wr` = !`wen_a_n` && `wen_b_ld`, and `fifo_rd` = !`ren_a_n` && !`ren_b_n`.
- R2: When `wen_b_ld` is low during reset, `load_mode` is 1 afterwards. It keeps that value until the next reset, regardless of later pin activity.
- R3: While `rst` is high at a rising write-clock edge, both offsets become 7. Both the write pointer and the read pointer return to slot 0.
- R4: The write pointer visits the slots in a fixed order and wraps back to slot 0 after slot 3: 0 = almost-empty low (`ae_ofs[8:0]`), 1 = almost-empty high (`ae_ofs[OFS_W-1:9]`), 2 = almost-full low (`af_ofs[8:0]`), 3 = almost-full high (`af_ofs[OFS_W-1:9]`). Each offset write advances the pointer by one.
- R5: An offset write happens at a rising `wr_clk` edge only when `load_mode`=1, `wen_a_n`=0 and `wen_b_ld`=0. In every other cycle, both offsets and the write pointer hold.
- R6: An offset read happens at a rising `rd_clk` edge when `load_mode`=1, `wen_b_ld`=0, `ren_a_n`=0 and `ren_b_n`=0. After that edge, `rdata` holds the slot addressed by the read pointer, `rdata_vld` is 1, and the read pointer advances in the order of R4. The read pointer is independent of the write pointer.
- R7: When a high slot is written, only `wdata[OFS_W-10:0]` is stored. When a high slot is read back, bits above those are 0.
- R8: In load mode, `fifo_wr` = !`wen_a_n` && `wen_b_ld`. `fifo_rd` is 0 during any offset read cycle.
- R9: If either read enable is high, no offset read happens. `rdata_vld` is 0 after that edge and the read pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst | input | 1 | Synchronous active-high reset, held over edges of both clocks |
| wen_a_n | input | 1 | First write enable, active low |
| wen_b_ld | input | 1 | Second write enable, or load strobe (active low) in load mode |
| ren_a_n | input | 1 | First read enable, active low |
| ren_b_n | input | 1 | Second read enable, active low |
| wdata | input | DATA_W | Write data word |
| load_mode | output | 1 | 1 when the load-strobe meaning was latched at reset |
| ae_ofs | output | OFS_W | Almost-empty offset |
| af_ofs | output | OFS_W | Almost-full offset |
| rdata | output | DATA_W | Offset half read back |
| rdata_vld | output | 1 | `rdata` was updated by the last read-clock edge |
| fifo_wr | output | 1 | Qualified FIFO data write strobe |
| fifo_rd | output | 1 | Qualified FIFO data read strobe |

## Verification
A write pointer in the wrong slot shows up on `ae_ofs`/`af_ofs` in the cycle after the misdirected write. A read pointer fault shows up on the very next read-back, because the expected value of every slot is known. A wrongly latched mode appears at `load_mode` immediately after reset, and on the offsets after the first strobed cycle. The bench drives long write sequences through many wraps, interleaves reads, and checks the offsets after every edge. A pointer that slips by one slot in either direction therefore fails within four accesses.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;
  typedef enum logic [1:0] {
    SLOT_AE_LO = 2'd0,
    SLOT_AE_HI = 2'd1,
    SLOT_AF_LO = 2'd2,
    SLOT_AF_HI = 2'd3
  } ofs_slot_e;

  localparam int OFS_RESET_VAL = 7;
endpackage

// File: rtl/fifo_ofs_mode_latch.sv
module fifo_ofs_mode_latch (
  input  logic clk,
  input  logic rst,
  input  logic pin_lvl,
  output logic load_mode
);
  // pin level sampled on every reset edge; frozen once reset drops
  always_ff @(posedge clk) begin
    if (rst) load_mode <= ~pin_lvl;
  end
endmodule

// File: rtl/fifo_ofs_wr_bank.sv
module fifo_ofs_wr_bank
  import fifo_ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs
);
  localparam int HI_W = OFS_W - DATA_W;
  localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(OFS_RESET_VAL);

  ofs_slot_e wr_ptr;
  logic [DATA_W-1:0] ae_lo, af_lo;
  logic [HI_W-1:0]   ae_hi, af_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= SLOT_AE_LO;
      ae_lo  <= RST_VAL[DATA_W-1:0];
      ae_hi  <= RST_VAL[OFS_W-1:DATA_W];
      af_lo  <= RST_VAL[DATA_W-1:0];
      af_hi  <= RST_VAL[OFS_W-1:DATA_W];
    end else if (wr_stb) begin
      unique case (wr_ptr)
        SLOT_AE_LO: ae_lo <= wdata;
        SLOT_AE_HI: ae_hi <= wdata[HI_W-1:0];
        SLOT_AF_LO: af_lo <= wdata;
        SLOT_AF_HI: af_hi <= wdata[HI_W-1:0];
      endcase
      wr_ptr <= ofs_slot_e'(wr_ptr + 2'd1);
    end
  end

  assign ae_ofs = {ae_hi, ae_lo};
  assign af_ofs = {af_hi, af_lo};
endmodule

// File: rtl/fifo_ofs_rd_port.sv
module fifo_ofs_rd_port
  import fifo_ofs_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic [OFS_W-1:0]  ae_ofs,
  input  logic [OFS_W-1:0]  af_ofs,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld
);
  localparam int HI_W  = OFS_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  ofs_slot_e rd_ptr;
  logic [DATA_W-1:0] sel;

  always_comb begin
    unique case (rd_ptr)
      SLOT_AE_LO: sel = ae_ofs[DATA_W-1:0];
      SLOT_AE_HI: sel = {{PAD_W{1'b0}}, ae_ofs[OFS_W-1:DATA_W]};
      SLOT_AF_LO: sel = af_ofs[DATA_W-1:0];
      SLOT_AF_HI: sel = {{PAD_W{1'b0}}, af_ofs[OFS_W-1:DATA_W]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr    <= SLOT_AE_LO;
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= rd_stb;
      if (rd_stb) begin
        rdata  <= sel;
        rd_ptr <= ofs_slot_e'(rd_ptr + 2'd1);
      end
    end
  end
endmodule

// File: rtl/fifo_ofs_port.sv
module fifo_ofs_port #(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 11
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst,
  input  logic              wen_a_n,
  input  logic              wen_b_ld,
  input  logic              ren_a_n,
  input  logic              ren_b_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              load_mode,
  output logic [OFS_W-1:0]  ae_ofs,
  output logic [OFS_W-1:0]  af_ofs,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_vld,
  output logic              fifo_wr,
  output logic              fifo_rd
);
  logic rd_load_mode;
  logic ofs_wr_stb, ofs_rd_stb;

  fifo_ofs_mode_latch u_mode_wr (
    .clk(wr_clk), .rst(rst), .pin_lvl(wen_b_ld), .load_mode(load_mode)
  );
  fifo_ofs_mode_latch u_mode_rd (
    .clk(rd_clk), .rst(rst), .pin_lvl(wen_b_ld), .load_mode(rd_load_mode)
  );

  assign ofs_wr_stb = load_mode    && !wen_a_n && !wen_b_ld;
  assign ofs_rd_stb = rd_load_mode && !wen_b_ld && !ren_a_n && !ren_b_n;

  // data strobes: the second pin is an active-high enable in both modes
  assign fifo_wr = !wen_a_n && wen_b_ld;
  assign fifo_rd = !ren_a_n && !ren_b_n && !ofs_rd_stb;

  fifo_ofs_wr_bank #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_bank (
    .clk(wr_clk), .rst(rst), .wr_stb(ofs_wr_stb), .wdata(wdata),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  fifo_ofs_rd_port #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_rd (
    .clk(rd_clk), .rst(rst), .rd_stb(ofs_rd_stb),
    .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .rdata(rdata), .rdata_vld(rdata_vld)
  );
endmodule

// File: rtl/fifo_ofs_port_chk.sv
module fifo_ofs_port_chk #(
  parameter int DATA_W = 9,
  parameter int OFS_W  = 11
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              rst,
  input logic              wen_a_n,
  input logic              wen_b_ld,
  input logic              ren_a_n,
  input logic              ren_b_n,
  input logic              load_mode,
  input logic [OFS_W-1:0]  ae_ofs,
  input logic [OFS_W-1:0]  af_ofs,
  input logic              rdata_vld,
  input logic              fifo_wr,
  input logic              fifo_rd
);
  p_rst_defaults_r3: assert property (@(posedge wr_clk) disable iff (rst)
    $past(rst) |-> (ae_ofs == OFS_W'(7) && af_ofs == OFS_W'(7)));

  p_hold_r5: assert property (@(posedge wr_clk) disable iff (rst)
    !(load_mode && !wen_a_n && !wen_b_ld) |=> ($stable(ae_ofs) && $stable(af_ofs)));

  p_mode_frozen_r2: assert property (@(posedge wr_clk) disable iff (rst)
    !$past(rst) |-> $stable(load_mode));

  p_no_fifo_wr_on_load_r8: assert property (@(posedge wr_clk) disable iff (rst)
    (load_mode && !wen_b_ld) |-> !fifo_wr);

  p_no_fifo_rd_on_load_r8: assert property (@(posedge rd_clk) disable iff (rst)
    (load_mode && !wen_b_ld && !ren_a_n && !ren_b_n) |-> !fifo_rd);

  p_rd_needs_both_r9: assert property (@(posedge rd_clk) disable iff (rst)
    (ren_a_n || ren_b_n) |=> !rdata_vld);

  p_enable_mode_quiet_r1: assert property (@(posedge rd_clk) disable iff (rst)
    !$past(rst) && !load_mode |-> !rdata_vld);
endmodule

bind fifo_ofs_port fifo_ofs_port_chk #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst),
  .wen_a_n(wen_a_n), .wen_b_ld(wen_b_ld), .ren_a_n(ren_a_n), .ren_b_n(ren_b_n),
  .load_mode(load_mode), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
  .rdata_vld(rdata_vld), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd)
);

// File: tb/fifo_ofs_port_tb.sv
module fifo_ofs_port_tb_top;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 9;
  localparam int OFS_W  = 11;
  localparam int HI_W   = OFS_W - DATA_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wen_a_n = 1'b1, wen_b_ld = 1'b1, ren_a_n = 1'b1, ren_b_n = 1'b1;
  logic [DATA_W-1:0] wdata = '0;
  logic load_mode, rdata_vld, fifo_wr, fifo_rd;
  logic [OFS_W-1:0] ae_ofs, af_ofs;
  logic [DATA_W-1:0] rdata;

  int checks = 0, failures = 0;
  int ae_m, af_m, wptr_m, rptr_m;
  int cycles = 0;

  always #(CLK_P/2) clk = ~clk;

  fifo_ofs_port #(.DATA_W(DATA_W), .OFS_W(OFS_W)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst(rst),
    .wen_a_n(wen_a_n), .wen_b_ld(wen_b_ld), .ren_a_n(ren_a_n), .ren_b_n(ren_b_n),
    .wdata(wdata), .load_mode(load_mode), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .rdata(rdata), .rdata_vld(rdata_vld), .fifo_wr(fifo_wr), .fifo_rd(fifo_rd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_ofs(input string req);
    chk(int'(ae_ofs) == ae_m, req, int'(ae_ofs), ae_m);
    chk(int'(af_ofs) == af_m, req, int'(af_ofs), af_m);
  endtask

  function automatic int exp_rd(input int slot);
    case (slot)
      0: return ae_m % 512;
      1: return ae_m >> DATA_W;
      2: return af_m % 512;
      default: return af_m >> DATA_W;
    endcase
  endfunction

  task automatic do_reset(input logic pin);
    @(negedge clk);
    rst = 1'b1; wen_b_ld = pin; wen_a_n = 1'b1; ren_a_n = 1'b1; ren_b_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0; wen_b_ld = 1'b1;
    ae_m = 7; af_m = 7; wptr_m = 0; rptr_m = 0;
  endtask

  task automatic ofs_write(input int v);
    @(negedge clk);
    wen_a_n = 1'b0; wen_b_ld = 1'b0; wdata = DATA_W'(v);
    #1 chk(fifo_wr == 1'b0, "R8 fifo_wr during load", int'(fifo_wr), 0);
    @(posedge clk);
    @(negedge clk);
    wen_a_n = 1'b1; wen_b_ld = 1'b1;
    case (wptr_m)
      0: ae_m = (ae_m & ~511) | (v % 512);
      1: ae_m = (ae_m % 512) | ((v % (1 << HI_W)) << DATA_W);
      2: af_m = (af_m & ~511) | (v % 512);
      default: af_m = (af_m % 512) | ((v % (1 << HI_W)) << DATA_W);
    endcase
    wptr_m = (wptr_m + 1) % 4;
    chk_ofs("R4 R7 write order");
  endtask

  task automatic ofs_read();
    int e;
    @(negedge clk);
    ren_a_n = 1'b0; ren_b_n = 1'b0; wen_b_ld = 1'b0;
    #1 chk(fifo_rd == 1'b0, "R8 fifo_rd during load", int'(fifo_rd), 0);
    e = exp_rd(rptr_m);
    @(posedge clk);
    @(negedge clk);
    ren_a_n = 1'b1; ren_b_n = 1'b1; wen_b_ld = 1'b1;
    chk(rdata_vld == 1'b1, "R6 rdata_vld", int'(rdata_vld), 1);
    chk(int'(rdata) == e, "R6 R7 readback", int'(rdata), e);
    rptr_m = (rptr_m + 1) % 4;
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    failures++; checks++;
    $display("FAIL watchdog act=%0d exp=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // enable mode
    do_reset(1'b1);
    chk(load_mode == 1'b0, "R1 mode", int'(load_mode), 0);
    chk_ofs("R3 reset offsets");
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      wen_a_n = c[0]; wen_b_ld = c[1]; ren_a_n = 1'b0; ren_b_n = 1'b0;
      #1;
      chk(fifo_wr == (!c[0] && c[1]), "R1 fifo_wr", int'(fifo_wr), int'(!c[0] && c[1]));
      chk(fifo_rd == 1'b1, "R1 fifo_rd", int'(fifo_rd), 1);
      @(posedge clk);
      @(negedge clk);
      chk_ofs("R1 offsets untouched");
      chk(rdata_vld == 1'b0, "R1 no readback", int'(rdata_vld), 0);
    end
    wen_a_n = 1'b1; wen_b_ld = 1'b1; ren_a_n = 1'b1; ren_b_n = 1'b1;

    // load mode
    do_reset(1'b0);
    chk(load_mode == 1'b1, "R2 mode", int'(load_mode), 1);
    chk_ofs("R3 reset offsets");
    for (int s = 0; s < 4; s++) ofs_read();
    for (int i = 0; i < 24; i++) begin
      ofs_write((i * 83 + 21) % 512);
      if (i % 3 == 2) ofs_read();
    end
    for (int s = 0; s < 6; s++) ofs_read();

    // idle and data cycles hold offsets and pointer
    @(negedge clk);
    wen_a_n = 1'b1; wen_b_ld = 1'b0; wdata = '1;
    @(posedge clk); @(negedge clk);
    chk_ofs("R5 idle hold");
    wen_a_n = 1'b0; wen_b_ld = 1'b1;
    #1 chk(fifo_wr == 1'b1, "R8 fifo_wr data", int'(fifo_wr), 1);
    @(posedge clk); @(negedge clk);
    chk_ofs("R5 data write hold");
    chk(load_mode == 1'b1, "R2 mode held", int'(load_mode), 1);
    wen_a_n = 1'b1;
    ofs_write(9'h1FF);

    // one read enable only
    for (int c = 1; c < 4; c++) begin
      @(negedge clk);
      wen_b_ld = 1'b0; ren_a_n = c[0]; ren_b_n = c[1];
      @(posedge clk); @(negedge clk);
      chk(rdata_vld == 1'b0, "R9 no readback", int'(rdata_vld), 0);
    end
    ren_a_n = 1'b1; ren_b_n = 1'b1; wen_b_ld = 1'b1;
    for (int s = 0; s < 4; s++) ofs_read();
    @(negedge clk);
    ren_a_n = 1'b0; ren_b_n = 1'b0;
    #1 chk(fifo_rd == 1'b1, "R8 fifo_rd data", int'(fifo_rd), 1);
    @(posedge clk); @(negedge clk);
    chk(rdata_vld == 1'b0, "R8 data read no readback", int'(rdata_vld), 0);
    ren_a_n = 1'b1; ren_b_n = 1'b1;

    // reset restores pointers and defaults
    do_reset(1'b0);
    chk_ofs("R3 second reset");
    ofs_read();
    ofs_write(300);
    ofs_read();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule